// File: doc/BRIEF.md
# Debounced Step Length Selector

This block turns a 10-bit position sample, such as a reading from a front-panel control, into one of four sequence lengths: 2, 4, 8 or 16 steps. A sequencer uses these lengths to size its shift window. A new selection takes effect only after it has been seen on a fixed number of consecutive valid samples. A control that is being turned, or that sits noisily on a boundary between two ranges, therefore cannot make the window length jump back and forth.

The block has two registered outputs. One is the confirmed length, as a plain binary number. The other is a window mask with the low `length` bits set, which the sequencer can AND directly with its state. Samples are accepted only on cycles where the valid strobe is high, so the block can sit behind a converter of any sampling rate.

Top module: `steplen_select`

## Requirements
- R1: A sample value maps to a length by range: values 0..255 give 2, 256..511 give 4, 512..767 give 8, and 768..1023 give 16.
- R2: While reset is low at a clock edge, the block is cleared. After that edge the length output is 16, the mask is 0xFFFF, the pending candidate is 16 and the stability count is 0.
- R3: If a valid sample maps to a different length than the pending candidate, that length becomes the new candidate and the count restarts at 0. Each following valid sample that maps to the candidate adds one to the count. The outputs take the candidate at the clock edge where the count reaches 8, so a new length needs 1 + 8 valid samples in a row.
- R4: If any valid sample maps elsewhere before the count reaches 8, the pending change is abandoned and the count starts again for the newest length. The outputs do not move.
- R5: Cycles with the valid strobe low are ignored. They neither advance nor clear the count, they do not change the candidate, and the outputs hold.
- R6: The mask output is 16 bits wide. Its low `length` bits are 1 and all higher bits are 0: 0x0003, 0x000F, 0x00FF or 0xFFFF.
- R7: The length output is a 5-bit unsigned binary value that is always one of 2, 4, 8 or 16.
- R8: The count saturates at 8. Any number of further matching samples leaves the outputs at the confirmed length, with no wrap and no retrigger of a stale value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld_i | input | 1 | High when `smp_val_i` holds a new sample |
| smp_val_i | input | 10 | Position sample, unsigned |
| len_o | output | 5 | Confirmed sequence length (2, 4, 8 or 16), registered |
| win_mask_o | output | 16 | Window mask with the low `len_o` bits set, registered |

## Verification
A wrong candidate or count stays hidden until it decides the outcome of a run. It then shows up as an output change one valid sample too early or too late, or as a change to the wrong length. The bench therefore compares both outputs every cycle against an independent model. Runs are held for 7, 8 and 9 samples, interrupted, and broken up by idle strobe gaps, so that an off-by-one count or a leaked idle cycle is reported within the first affected edge. Random runs with long holds and frequent changes cover boundary samples at 255/256, 511/512 and 767/768.

// File: rtl/steplen_pkg.sv
// Package: shared defaults and helpers for the step length selector.
// Assumes lengths are powers of two from 2 up to 2**LOG2_MAX.
package steplen_pkg;
    localparam int unsigned DEF_SAMPLE_W  = 10;
    localparam int unsigned DEF_LOG2_MAX  = 4;
    localparam int unsigned DEF_STABLE_N  = 8;

    // Number of steps selected by a level code (code 0 -> 2 steps).
    function automatic int unsigned steps_of(input int unsigned code);
        return 32'd2 << code;
    endfunction
endpackage

// File: rtl/steplen_quant.sv
// Module: steplen_quant
// Splits the sample range into NUM_LVL equal bands and returns the band
// index as a level code. Purely combinational.
// Assumes NUM_LVL <= 2**SAMPLE_W.
module steplen_quant #(
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned NUM_LVL  = 4,
    localparam int unsigned CODE_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [CODE_W-1:0]   code_o
);
    localparam int unsigned PROD_W = SAMPLE_W + CODE_W + 1;

    generate
        if ((NUM_LVL & (NUM_LVL - 1)) == 0) begin : g_pow2
            // Equal power-of-two bands: the top bits are the band index.
            assign code_o = sample_i[SAMPLE_W-1 -: CODE_W];
        end else begin : g_scaled
            logic [PROD_W-1:0] prod;
            // Scale the sample by the band count; the high part is the index.
            always_comb begin
                prod   = PROD_W'(sample_i) * PROD_W'(NUM_LVL);
                code_o = CODE_W'(prod >> SAMPLE_W);
            end
        end
    endgenerate
endmodule

// File: rtl/steplen_stable.sv
// Module: steplen_stable
// Tracks a pending level candidate and counts consecutive valid samples
// that agree with it. Emits a one-cycle commit when the count reaches
// STABLE_N. Assumes the level code at reset is the largest one.
module steplen_stable #(
    parameter int unsigned CODE_W   = 2,
    parameter int unsigned STABLE_N = 8,
    localparam int unsigned CNT_W   = $clog2(STABLE_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              commit_o,
    output logic [CODE_W-1:0] cand_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STABLE_N);

    logic [CODE_W-1:0] cand_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic              match;

    // Saturating increment and agreement test.
    always_comb begin
        match    = (code_i == cand_q);
        cnt_inc  = (cnt_q < CNT_TOP) ? cnt_q + 1'b1 : cnt_q;
        commit_o = vld_i && match && (cnt_inc == CNT_TOP);
        cand_o   = cand_q;
    end

    // Candidate and count registers, updated only on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '1;
            cnt_q  <= '0;
        end else if (vld_i) begin
            if (match) begin
                cnt_q <= cnt_inc;
            end else begin
                cand_q <= code_i;
                cnt_q  <= '0;
            end
        end
    end

    // R8: the count never passes its ceiling.
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_TOP);

    // R5: idle strobe cycles leave candidate and count untouched.
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(cand_q) && $stable(cnt_q)));

    // R4: a disagreeing sample restarts the count.
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !match) |=> (cnt_q == '0));

    // R3: a commit only comes from a count that is one short or saturated.
    p_commit_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (cnt_q >= CNT_TOP - 1'b1));
endmodule

// File: rtl/steplen_out.sv
// Module: steplen_out
// Holds the confirmed level and drives the registered length and window
// mask. Loads a new level only on a commit pulse.
// Assumes MASK_W = 2**(NUM_LVL) and the reset level is the largest.
module steplen_out #(
    parameter int unsigned CODE_W = 2,
    parameter int unsigned LEN_W  = 5,
    parameter int unsigned MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [LEN_W-1:0]  len_o,
    output logic [MASK_W-1:0] mask_o
);
    logic [LEN_W-1:0]  len_d;
    logic [MASK_W-1:0] mask_d;

    // Length and mask belonging to the incoming level code.
    always_comb begin
        len_d = LEN_W'(steplen_pkg::steps_of(int'(code_i)));
        for (int i = 0; i < MASK_W; i++) begin
            mask_d[i] = (i < int'(len_d));
        end
    end

    // Output registers, loaded at reset or on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_o  <= LEN_W'(MASK_W);
            mask_o <= '1;
        end else if (commit_i) begin
            len_o  <= len_d;
            mask_o <= mask_d;
        end
    end

    // R2: reset leaves the largest length and a full mask.
    p_reset_val_r2: assert property (@(posedge clk)
        !rst_n |=> (len_o == LEN_W'(MASK_W) && mask_o == '1));

    // R7: length is always a single power of two, never 1.
    p_len_pow2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(len_o) && !len_o[0]);

    // R6: mask population equals length and the mask is contiguous from bit 0.
    p_mask_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mask_o) == int'(len_o)) && mask_o[0] && ((mask_o & (mask_o + 1'b1)) == '0));

    // R5: without a commit the outputs hold.
    p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(len_o) && $stable(mask_o)));
endmodule

// File: rtl/steplen_select.sv
// Module: steplen_select (top)
// Quantises position samples into power-of-two lengths and applies a new
// length only after it has been seen STABLE_N + 1 valid samples in a row
// (one to nominate, STABLE_N to confirm). Outputs are registered.
// Assumes synchronous, active-low reset and one sample per valid cycle.
module steplen_select #(
    parameter int unsigned SAMPLE_W = steplen_pkg::DEF_SAMPLE_W,
    parameter int unsigned LOG2_MAX = steplen_pkg::DEF_LOG2_MAX,
    parameter int unsigned STABLE_N = steplen_pkg::DEF_STABLE_N,
    localparam int unsigned NUM_LVL = LOG2_MAX,
    localparam int unsigned CODE_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int unsigned LEN_W   = LOG2_MAX + 1,
    localparam int unsigned MASK_W  = 1 << LOG2_MAX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld_i,
    input  logic [SAMPLE_W-1:0] smp_val_i,
    output logic [LEN_W-1:0]    len_o,
    output logic [MASK_W-1:0]   win_mask_o
);
    logic [CODE_W-1:0] lvl_code;
    logic [CODE_W-1:0] cand_code;
    logic              commit;

    steplen_quant #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_LVL  (NUM_LVL)
    ) u_quant (
        .sample_i (smp_val_i),
        .code_o   (lvl_code)
    );

    steplen_stable #(
        .CODE_W   (CODE_W),
        .STABLE_N (STABLE_N)
    ) u_stable (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (smp_vld_i),
        .code_i   (lvl_code),
        .commit_o (commit),
        .cand_o   (cand_code)
    );

    steplen_out #(
        .CODE_W   (CODE_W),
        .LEN_W    (LEN_W),
        .MASK_W   (MASK_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .code_i   (cand_code),
        .len_o    (len_o),
        .mask_o   (win_mask_o)
    );

    // R1: a commit always carries the level of the sample that triggered it.
    p_commit_lvl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cand_code == lvl_code));
endmodule

// File: tb/sim_steplen_select.sv
module sim_steplen_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld = 1'b0;
    logic [9:0] smp = '0;
    logic [4:0] len;
    logic [15:0] mask;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    int m_cand = 16;
    int m_cnt  = 0;
    int m_conf = 16;

    always #5 clk = ~clk;

    steplen_select u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(vld), .smp_val_i(smp),
        .len_o(len), .win_mask_o(mask)
    );

    function automatic int map_len(input int v);
        if (v < 256) return 2;
        else if (v < 512) return 4;
        else if (v < 768) return 8;
        return 16;
    endfunction

    function automatic int exp_mask(input int l);
        return (l >= 16) ? 32'hFFFF : ((1 << l) - 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive, advance model at edge, compare just after.
    task automatic step(input bit v, input int s, input string req);
        vld = v;
        smp = 10'(s);
        @(posedge clk);
        if (v) begin
            int q = map_len(s);
            if (q == m_cand) begin
                if (m_cnt < 8) m_cnt++;
                if (m_cnt == 8) m_conf = m_cand;
            end else begin
                m_cand = q;
                m_cnt = 0;
            end
        end
        #1;
        check(req, int'(len), m_conf);
        check(req, int'(mask), exp_mask(m_conf));
    endtask

    task automatic hold(input int s, input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b1, s, req);
    endtask

    initial begin
        #5ms;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset len", int'(len), 16);
        check("R2 reset mask", int'(mask), 16'hFFFF);
        rst_n = 1'b1;

        // R3: 1 nominate + 7 agree: no change; the 8th agreement commits.
        hold(100, 8, "R3 short run");
        check("R3 not yet", int'(len), 16);
        hold(100, 1, "R3 commit");
        check("R3 committed 2", int'(len), 2);
        check("R6 mask 2", int'(mask), 16'h0003);
        // R8: long holding keeps the value
        hold(100, 20, "R8 saturate");

        // R1 boundaries
        hold(255, 9, "R1 255");
        hold(256, 9, "R1 256");
        check("R1 256 -> 4", int'(len), 4);
        check("R6 mask 4", int'(mask), 16'h000F);
        hold(511, 9, "R1 511");
        hold(512, 9, "R1 512");
        check("R1 512 -> 8", int'(len), 8);
        check("R6 mask 8", int'(mask), 16'h00FF);
        hold(767, 9, "R1 767");
        hold(768, 9, "R1 768");
        check("R7 len 16", int'(len), 16);
        hold(1023, 3, "R1 1023");
        hold(0, 9, "R1 0");

        // R4: interrupt at the 7th agreement, then return
        hold(600, 7, "R4 partial");
        hold(300, 1, "R4 interrupt");
        hold(600, 8, "R4 restart");
        check("R4 still old", int'(len), 2);
        hold(600, 1, "R4 commit after restart");
        check("R4 new", int'(len), 8);

        // R5: idle gaps with garbage samples do not count or clear
        hold(900, 4, "R5 before gap");
        for (int i = 0; i < 6; i++) step(1'b0, 10, "R5 idle");
        hold(900, 4, "R5 after gap");
        check("R5 not yet", int'(len), 8);
        hold(900, 1, "R5 commit");
        check("R5 gap ignored", int'(len), 16);

        // Random runs with held levels and idle cycles.
        for (int r = 0; r < 400; r++) begin
            int s = int'($urandom_range(0, 1023));
            int n = int'($urandom_range(1, 14));
            for (int k = 0; k < n; k++) begin
                bit v = ($urandom_range(0, 9) < 8);
                int sv = ($urandom_range(0, 15) == 0) ? int'($urandom_range(0, 1023)) : s;
                step(v, sv, "R3 random");
            end
        end

        // R2: reset mid-run
        rst_n = 1'b0;
        vld = 1'b0;
        @(posedge clk);
        #1;
        m_cand = 16; m_cnt = 0; m_conf = 16;
        check("R2 reset again", int'(len), 16);
        check("R2 reset mask again", int'(mask), 16'hFFFF);
        rst_n = 1'b1;
        hold(50, 9, "R2 after reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule